// File: doc/BRIEF.md
# Legacy and Message-Signalled Interrupt Aggregator

This block gathers interrupt traffic arriving from a link controller and folds it into one host interrupt line. Legacy line events (assert or deassert of one of four lines) and message-signalled writes (a vector number plus a data byte) come in as single-cycle pulses. Power-state-change and flush notifications arrive the same way. Each event sets a sticky bit in a status register. Software clears a status bit by writing 1 to it.

Status is arranged in three levels. A 32-entry message vector, gated by its own mask, raises a pending bit in the primary status register. The primary and secondary registers, each gated by its mask, raise the core bit of the top status register. The top register, gated by its mask, drives the registered interrupt output. The data byte of the most recent message write is held in a read-only register so software can read it.

A simple word-addressed register port gives access to every register. Each mask register sits at the word after its status register. Reads are combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: A legacy event on line k (0 to 3) sets primary status bit 16+k when intx_deassert is 0, and bit 20+k when it is 1. The primary status register is at word 0.
- R2: A power-state event sets secondary status bit 4 and a flush event sets bit 5. The secondary status register is at word 2.
- R3: A message write with vector v sets bit v of the message status register at word 4. It also loads msi_data into the payload register at word 8, which reads back zero-extended.
- R4: Primary status bit 24 is set one cycle after the message status register holds any bit whose mask bit at word 5 is 0. Masked message bits never set it.
- R5: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing a status register never sets a bit.
- R6: When an event sets a status bit in the same cycle that software writes 1 to that bit, the bit ends up set.
- R7: Each mask register sits at the word after its status register (words 1, 3, 5, 7). A mask bit of 1 blocks its source. Only implemented bits are stored: primary 26:0, secondary 5:4, message 31:0, top 16. Unimplemented bits read 0.
- R8: Top status bit 16 (word 6) is set one cycle after any unmasked primary or secondary status bit is present. Masked bits do not set it.
- R9: irq_o is the registered result of top status bit 16 AND NOT top mask bit 16. It follows changes to either one a single cycle later.
- R10: After reset, every status register and the payload read 0, and every mask reads as its implemented field all ones (0x07FFFFFF, 0x30, 0xFFFFFFFF, 0x00010000). irq_o is 0, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| intx_evt | input | 1 | Legacy line event pulse |
| intx_deassert | input | 1 | 1: deassert event, 0: assert event |
| intx_line | input | 2 | Legacy line number |
| pm_evt | input | 1 | Power-state-change event pulse |
| flush_evt | input | 1 | Flush event pulse |
| msi_wr | input | 1 | Message-signalled write pulse |
| msi_vec | input | 5 | Message vector number |
| msi_data | input | 8 | Message data byte |
| irq_o | output | 1 | Summary interrupt to host |

## Verification
Legacy assert and deassert events are driven on different lines, so a wrong bit offset or a swapped assert/deassert field shows up. Message writes go to an unmasked vector, a masked vector and both ends of the vector range (bits 0 and 31). These separate "any status bit" from "any unmasked status bit" in the pending logic, and show whether the payload follows the latest write. Secondary events are left masked while primary events are unmasked, which shows that masking is applied per stage. Clear-with-zero, partial clears, a clear in the same cycle as a set, and toggling of the primary and top masks each test one edge of the sticky and gating behaviour.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int REG_W         = 32;
    localparam int ADDR_W        = 4;
    localparam int NUM_BANKS     = 4;
    localparam int VEC_W         = $clog2(REG_W);
    localparam int PAYLOAD_W     = 8;
    localparam int INTX_LINES    = 4;
    localparam int LINE_W        = $clog2(INTX_LINES);
    localparam int ASSERT_BASE   = 16;
    localparam int DEASSERT_BASE = ASSERT_BASE + INTX_LINES;
    localparam int MSI_PEND_BIT  = 24;
    localparam int PRIM_TOP_BIT  = 26;
    localparam int PM_BIT        = 4;
    localparam int FLUSH_BIT     = 5;
    localparam int CORE_BIT      = 16;

    localparam logic [ADDR_W-1:0] ADDR_PAYLOAD = ADDR_W'(2 * NUM_BANKS);

    // bank index b: status at word 2b, mask at word 2b+1
    typedef enum logic [1:0] {
        BK_PRIM = 2'd0,
        BK_SEC  = 2'd1,
        BK_MSI  = 2'd2,
        BK_TOP  = 2'd3
    } bank_e;

    typedef struct packed {
        logic              valid;
        logic              deassert;
        logic [LINE_W-1:0] line;
    } intx_evt_t;

    function automatic logic [REG_W-1:0] bank_valid(bank_e b);
        logic [REG_W-1:0] v;
        case (b)
            BK_PRIM: v = {{(REG_W-PRIM_TOP_BIT-1){1'b0}}, {(PRIM_TOP_BIT+1){1'b1}}};
            BK_SEC:  v = (REG_W'(1) << PM_BIT) | (REG_W'(1) << FLUSH_BIT);
            BK_MSI:  v = '1;
            default: v = REG_W'(1) << CORE_BIT;
        endcase
        return v;
    endfunction

    // sticky status update: clear-by-one, then new events win
    function automatic logic [REG_W-1:0] w1c_next(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] clr,
        input logic [REG_W-1:0] set,
        input logic [REG_W-1:0] valid
    );
        return ((cur & ~clr) | set) & valid;
    endfunction

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
    import irqagg_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_i,
    input  logic             stat_wr_i,
    input  logic             mask_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] mask_o,
    output logic             pend_o
);

    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] clr;

    assign clr = stat_wr_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= VALID;
        end else begin
            stat_q <= w1c_next(stat_q, clr, set_i, VALID);
            if (mask_wr_i) begin
                mask_q <= wdata_i & VALID;
            end
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign pend_o = |(stat_q & ~mask_q);

endmodule

// File: rtl/intx_set_decode.sv
module intx_set_decode
    import irqagg_pkg::*;
(
    input  intx_evt_t        evt_i,
    output logic [REG_W-1:0] set_o
);

    always_comb begin
        set_o = '0;
        if (evt_i.valid) begin
            if (evt_i.deassert) begin
                set_o[DEASSERT_BASE + int'(evt_i.line)] = 1'b1;
            end else begin
                set_o[ASSERT_BASE + int'(evt_i.line)] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              intx_evt,
    input  logic              intx_deassert,
    input  logic [LINE_W-1:0] intx_line,
    input  logic              pm_evt,
    input  logic              flush_evt,
    input  logic              msi_wr,
    input  logic [VEC_W-1:0]  msi_vec,
    input  logic [PAYLOAD_W-1:0] msi_data,
    output logic              irq_o
);

    logic [REG_W-1:0] set_v  [NUM_BANKS];
    logic [REG_W-1:0] stat_v [NUM_BANKS];
    logic [REG_W-1:0] mask_v [NUM_BANKS];
    logic [NUM_BANKS-1:0] pend_v;

    logic [REG_W-1:0]     intx_set;
    intx_evt_t            intx_in;
    logic [PAYLOAD_W-1:0] payload_q;
    logic                 irq_q;

    assign intx_in = '{valid: intx_evt, deassert: intx_deassert, line: intx_line};

    intx_set_decode u_intx (
        .evt_i (intx_in),
        .set_o (intx_set)
    );

    assign set_v[BK_PRIM] = intx_set | (REG_W'(pend_v[BK_MSI]) << MSI_PEND_BIT);
    assign set_v[BK_SEC]  = (REG_W'(pm_evt) << PM_BIT) | (REG_W'(flush_evt) << FLUSH_BIT);
    assign set_v[BK_MSI]  = msi_wr ? (REG_W'(1) << msi_vec) : '0;
    assign set_v[BK_TOP]  = REG_W'(pend_v[BK_PRIM] | pend_v[BK_SEC]) << CORE_BIT;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * g);
        logic stat_wr;
        logic mask_wr;
        assign stat_wr = reg_wr && (reg_addr == STAT_ADDR);
        assign mask_wr = reg_wr && (reg_addr == STAT_ADDR + ADDR_W'(1));

        irq_stat_bank #(
            .VALID (bank_valid(bank_e'(g)))
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .set_i     (set_v[g]),
            .stat_wr_i (stat_wr),
            .mask_wr_i (mask_wr),
            .wdata_i   (reg_wdata),
            .stat_o    (stat_v[g]),
            .mask_o    (mask_v[g]),
            .pend_o    (pend_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            payload_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (msi_wr) begin
                payload_q <= msi_data;
            end
            irq_q <= pend_v[BK_TOP];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_PAYLOAD) begin
            reg_rdata = reg_addr[0] ? mask_v[reg_addr[ADDR_W-1:1]]
                                    : stat_v[reg_addr[ADDR_W-1:1]];
        end else if (reg_addr == ADDR_PAYLOAD) begin
            reg_rdata = REG_W'(payload_q);
        end
    end

    assign irq_o = irq_q;

    // named views for the bound checker
    logic [REG_W-1:0] prim_stat, sec_stat, msi_stat, msi_mask, top_stat, top_mask;
    assign prim_stat = stat_v[BK_PRIM];
    assign sec_stat  = stat_v[BK_SEC];
    assign msi_stat  = stat_v[BK_MSI];
    assign msi_mask  = mask_v[BK_MSI];
    assign top_stat  = stat_v[BK_TOP];
    assign top_mask  = mask_v[BK_TOP];

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic                 intx_evt,
    input logic                 intx_deassert,
    input logic [LINE_W-1:0]    intx_line,
    input logic                 pm_evt,
    input logic                 flush_evt,
    input logic                 msi_wr,
    input logic [VEC_W-1:0]     msi_vec,
    input logic [PAYLOAD_W-1:0] msi_data,
    input logic                 irq_o,
    input logic [REG_W-1:0]     prim_stat,
    input logic [REG_W-1:0]     sec_stat,
    input logic [REG_W-1:0]     msi_stat,
    input logic [REG_W-1:0]     msi_mask,
    input logic [REG_W-1:0]     top_stat,
    input logic [REG_W-1:0]     top_mask,
    input logic [PAYLOAD_W-1:0] payload_q
);

    assert_intx_sets_R1: assert property (@(posedge clk) disable iff (rst)
        intx_evt |=> prim_stat[ASSERT_BASE + 4 * int'($past(intx_deassert)) + int'($past(intx_line))]);

    assert_msi_capture_R3: assert property (@(posedge clk) disable iff (rst)
        msi_wr |=> (msi_stat[$past(msi_vec)] && payload_q == $past(msi_data)));

    assert_w1c_sec_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'd2 && !pm_evt && !flush_evt) |=> ((sec_stat & $past(reg_wdata)) == '0));

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (msi_wr && reg_wr && reg_addr == 4'd4) |=> msi_stat[$past(msi_vec)]);

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'd5) |=> (msi_mask == $past(reg_wdata)));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(top_stat[CORE_BIT] && !top_mask[CORE_BIT]));

endmodule

bind irq_aggregator irqagg_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .intx_evt      (intx_evt),
    .intx_deassert (intx_deassert),
    .intx_line     (intx_line),
    .pm_evt        (pm_evt),
    .flush_evt     (flush_evt),
    .msi_wr        (msi_wr),
    .msi_vec       (msi_vec),
    .msi_data      (msi_data),
    .irq_o         (irq_o),
    .prim_stat     (prim_stat),
    .sec_stat      (sec_stat),
    .msi_stat      (msi_stat),
    .msi_mask      (msi_mask),
    .top_stat      (top_stat),
    .top_mask      (top_mask),
    .payload_q     (payload_q)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        intx_evt = 1'b0;
    logic        intx_deassert = 1'b0;
    logic [1:0]  intx_line = '0;
    logic        pm_evt = 1'b0;
    logic        flush_evt = 1'b0;
    logic        msi_wr = 1'b0;
    logic [4:0]  msi_vec = '0;
    logic [7:0]  msi_data = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    irq_aggregator u0 (
        .clk (clk), .rst (rst),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .intx_evt (intx_evt), .intx_deassert (intx_deassert), .intx_line (intx_line),
        .pm_evt (pm_evt), .flush_evt (flush_evt),
        .msi_wr (msi_wr), .msi_vec (msi_vec), .msi_data (msi_data),
        .irq_o (irq_o)
    );

    // {is_read, addr, data/expected}
    localparam int NV = 22;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 4'd0, 32'h0000_0000}, {1'b1, 4'd1, 32'h07FF_FFFF},
        {1'b1, 4'd2, 32'h0000_0000}, {1'b1, 4'd3, 32'h0000_0030},
        {1'b1, 4'd4, 32'h0000_0000}, {1'b1, 4'd5, 32'hFFFF_FFFF},
        {1'b1, 4'd6, 32'h0000_0000}, {1'b1, 4'd7, 32'h0001_0000},
        {1'b1, 4'd8, 32'h0000_0000}, {1'b1, 4'd9, 32'h0000_0000},
        {1'b0, 4'd0, 32'hFFFF_FFFF}, {1'b1, 4'd0, 32'h0000_0000},
        {1'b0, 4'd1, 32'h0000_0000}, {1'b1, 4'd1, 32'h0000_0000},
        {1'b0, 4'd3, 32'hFFFF_FFFF}, {1'b1, 4'd3, 32'h0000_0030},
        {1'b0, 4'd5, 32'h0000_FFFF}, {1'b1, 4'd5, 32'h0000_FFFF},
        {1'b0, 4'd7, 32'h0000_0000}, {1'b1, 4'd7, 32'h0000_0000},
        {1'b0, 4'd6, 32'hFFFF_FFFF}, {1'b1, 4'd6, 32'h0000_0000}
    };

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic intx_pulse(input logic deas, input logic [1:0] ln);
        intx_evt = 1'b1; intx_deassert = deas; intx_line = ln;
        @(negedge clk);
        intx_evt = 1'b0; intx_deassert = 1'b0; intx_line = '0;
    endtask

    task automatic msi_pulse(input logic [4:0] v, input logic [7:0] d);
        msi_wr = 1'b1; msi_vec = v; msi_data = d;
        @(negedge clk);
        msi_wr = 1'b0; msi_vec = '0; msi_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        check("R10 irq after reset", 32'(irq_o), 32'd0);

        // R10 reset values, R5 write-never-sets, R7 mask storage
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) rd_check("R10/R7 register table", VEC[i][35:32], VEC[i][31:0]);
            else            wr(VEC[i][35:32], VEC[i][31:0]);
        end

        // R1 assert on line 2, R8 propagation, R9 output
        intx_pulse(1'b0, 2'd2);
        rd_check("R1 assert line 2", 4'd0, 32'h0004_0000);
        idle(1);
        rd_check("R8 core bit set", 4'd6, 32'h0001_0000);
        idle(1);
        check("R9 irq raised", 32'(irq_o), 32'd1);

        // R5 clear semantics, R9 fall
        wr(4'd0, 32'h0000_0000);
        rd_check("R5 zero write keeps", 4'd0, 32'h0004_0000);
        wr(4'd0, 32'h0004_0000);
        rd_check("R5 one write clears", 4'd0, 32'h0000_0000);
        wr(4'd6, 32'h0001_0000);
        idle(1);
        check("R9 irq fall", 32'(irq_o), 32'd0);

        // R1 deassert on line 1
        intx_pulse(1'b1, 2'd1);
        rd_check("R1 deassert line 1", 4'd0, 32'h0020_0000);
        idle(2);
        wr(4'd0, 32'h0020_0000);
        wr(4'd6, 32'h0001_0000);
        idle(1);

        // R2 secondary events, masked so R8 blocks
        pm_evt = 1'b1; @(negedge clk); pm_evt = 1'b0;
        rd_check("R2 power state bit", 4'd2, 32'h0000_0010);
        flush_evt = 1'b1; @(negedge clk); flush_evt = 1'b0;
        rd_check("R2 flush bit", 4'd2, 32'h0000_0030);
        idle(2);
        rd_check("R8 masked secondary", 4'd6, 32'h0000_0000);
        wr(4'd2, 32'h0000_0010);
        rd_check("R5 partial clear", 4'd2, 32'h0000_0020);
        wr(4'd2, 32'h0000_0020);

        // R3 / R4 message path
        msi_pulse(5'd20, 8'hA5);
        rd_check("R3 msi status", 4'd4, 32'h0010_0000);
        rd_check("R3 payload", 4'd8, 32'h0000_00A5);
        idle(1);
        rd_check("R4 pending bit", 4'd0, 32'h0100_0000);
        idle(2);
        check("R9 irq from msi", 32'(irq_o), 32'd1);
        msi_pulse(5'd3, 8'h3C);
        rd_check("R3 masked vector stored", 4'd4, 32'h0010_0008);
        rd_check("R3 payload updated", 4'd8, 32'h0000_003C);
        wr(4'd4, 32'h0010_0000);
        wr(4'd0, 32'h0100_0000);
        rd_check("R4 masked vector not pending", 4'd0, 32'h0000_0000);
        wr(4'd6, 32'h0001_0000);
        idle(1);
        msi_pulse(5'd31, 8'h81);
        rd_check("R3 vector 31", 4'd4, 32'h8000_0008);
        msi_pulse(5'd0, 8'h42);
        rd_check("R3 vector 0", 4'd4, 32'h8000_0009);
        rd_check("R3 payload last", 4'd8, 32'h0000_0042);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd6, 32'hFFFF_FFFF);
        idle(1);
        rd_check("R5 msi cleared", 4'd4, 32'h0000_0000);

        // R6 set wins over clear
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFF;
        intx_evt = 1'b1; intx_line = 2'd0;
        @(negedge clk);
        reg_wr = 1'b0; intx_evt = 1'b0;
        rd_check("R6 primary set wins", 4'd0, 32'h0001_0000);
        reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0000_0020;
        msi_wr = 1'b1; msi_vec = 5'd5; msi_data = 8'h11;
        @(negedge clk);
        reg_wr = 1'b0; msi_wr = 1'b0;
        rd_check("R6 msi set wins", 4'd4, 32'h0000_0020);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd6, 32'hFFFF_FFFF);
        idle(1);

        // R7 primary mask blocks, then unmask
        wr(4'd1, 32'h0002_0000);
        intx_pulse(1'b0, 2'd1);
        rd_check("R1 assert line 1", 4'd0, 32'h0002_0000);
        idle(2);
        rd_check("R7 masked source blocked", 4'd6, 32'h0000_0000);
        check("R7 irq quiet when masked", 32'(irq_o), 32'd0);
        wr(4'd1, 32'h0000_0000);
        idle(1);
        rd_check("R7 unmask propagates", 4'd6, 32'h0001_0000);

        // R9 top mask gates output
        wr(4'd7, 32'h0001_0000);
        idle(1);
        check("R9 top mask gates irq", 32'(irq_o), 32'd0);
        rd_check("R9 top status kept", 4'd6, 32'h0001_0000);

        summary();
    end

endmodule